// File: doc/BRIEF.md
# Burst address sequence generator

This block produces the word address for a four-beat burst memory access. A burst begins when either of two start strobes is seen: one driven by the processor, one by the memory controller. The block then holds the upper address bits of the captured start address. It generates the low two bits itself and steps them one beat on every clock where the advance input is high.

The beat order is set by a static mode pin. In linear order the low bits count up from the start value and wrap within the group of four. In interleaved order the low bits are the start value XOR the beat number. The address, both strobes and the advance input pass through one stage of rising-edge registers before they act. The mode pin is not registered. A change on it reaches the output with no clock edge.

The sequencer has two states. SEQ_IDLE is entered at reset and means no burst has been loaded. SEQ_RUN means a start address is held. There are three transitions. SEQ_IDLE goes to SEQ_RUN on a start. SEQ_RUN goes to SEQ_RUN on a start, which reloads the address and clears the beat count. SEQ_RUN goes to SEQ_RUN on an advance, which steps the beat count. With no start and no advance, either state holds.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, addr_out and beat_cnt are both zero.
- R2: A start on strobe_cpu alone, or on strobe_ctl alone, loads addr_in. Two rising edges after the strobe is sampled, addr_out equals the loaded address and beat_cnt is 0.
- R3: When both strobes are high on the same edge, the result is a single load. It is the same as a load by one strobe.
- R4: When a burst is loaded, each sampled advance raises beat_cnt by one, two edges later. With no advance, beat_cnt and addr_out hold.
- R5: When mode_ilv is 0 (linear), addr_out[1:0] equals (start[1:0] + beat_cnt) mod 4.
- R6: When mode_ilv is 1 (interleaved), addr_out[1:0] equals start[1:0] XOR beat_cnt.
- R7: After four advances, beat_cnt wraps to 0 and addr_out returns to the start address. The bits above bit 1 never change except on a load.
- R8: A start in the middle of a burst aborts it. The new address is loaded with beat_cnt 0, even when advance is high on the same edge.
- R9: Before the first load, advance has no effect. addr_out and beat_cnt stay zero.
- R10: mode_ilv is not registered. A change on it is reflected on addr_out[1:0] with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_ilv | input | 1 | Beat order: 0 linear, 1 interleaved (static, unregistered) |
| strobe_cpu | input | 1 | Processor-side burst start |
| strobe_ctl | input | 1 | Controller-side burst start |
| advance | input | 1 | Step the burst by one beat |
| addr_in | input | ADDR_W | Start address |
| addr_out | output | ADDR_W | Current word address |
| beat_cnt | output | CNT_W | Beats advanced since the last load |

## Verification
The sweep loads every low start value under both orders, with each of the three strobe combinations. It then advances six times, so the beats pass the wrap point. This separates linear from interleaved order, shows that the upper bits stay fixed across the wrap, and shows that the two strobes and the double strobe behave the same. An idle gap without advance shows that the address holds between steps. A strobe that arrives together with advance in mid-burst shows that the load takes priority. Advancing before any load shows that the idle state ignores advance. A mode flip with no clock shows that the mode pin acts combinationally.

// File: rtl/burst_pkg.sv
package burst_pkg;
    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/burst_in_reg.sv
module burst_in_reg #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_cpu,
    input  logic              strobe_ctl,
    input  logic              advance,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              cap_load,
    output logic              cap_adv,
    output logic [ADDR_W-1:0] cap_addr
);
    // Single capture stage for every clocked control and the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_load <= 1'b0;
            cap_adv  <= 1'b0;
            cap_addr <= '0;
        end else begin
            cap_load <= strobe_cpu | strobe_ctl;
            cap_adv  <= advance;
            cap_addr <= addr_in;
        end
    end
endmodule

// File: rtl/burst_seq_fsm.sv
module burst_seq_fsm
    import burst_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_load,
    input  logic              cap_adv,
    input  logic [ADDR_W-1:0] cap_addr,
    output logic [ADDR_W-1:0] base_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              run_q
);
    seq_state_e state_q, state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // Next state: any start enters or re-enters SEQ_RUN.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (cap_load) state_d = SEQ_RUN;
            SEQ_RUN:  state_d = SEQ_RUN;
            default:  state_d = SEQ_IDLE;
        endcase
    end

    // Outputs: base address and beat counter; load beats advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (cap_load) begin
                        base_q <= cap_addr;
                        cnt_q  <= '0;
                    end
                end
                SEQ_RUN: begin
                    if (cap_load) begin
                        base_q <= cap_addr;
                        cnt_q  <= '0;
                    end else if (cap_adv) begin
                        cnt_q  <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    base_q <= '0;
                    cnt_q  <= '0;
                end
            endcase
        end
    end

    assign run_q = (state_q == SEQ_RUN);
endmodule

// File: rtl/burst_addr_mix.sv
module burst_addr_mix #(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 2
) (
    input  logic              mode_ilv,
    input  logic [ADDR_W-1:0] base_q,
    input  logic [CNT_W-1:0]  cnt_q,
    output logic [ADDR_W-1:0] addr_out
);
    logic [CNT_W-1:0] lin_lo;
    logic [CNT_W-1:0] ilv_lo;

    assign lin_lo = base_q[CNT_W-1:0] + cnt_q;

    for (genvar i = 0; i < CNT_W; i++) begin : g_ilv
        assign ilv_lo[i] = base_q[i] ^ cnt_q[i];
    end

    assign addr_out = {base_q[ADDR_W-1:CNT_W], (mode_ilv ? ilv_lo : lin_lo)};
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_ilv,
    input  logic              strobe_cpu,
    input  logic              strobe_ctl,
    input  logic              advance,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [CNT_W-1:0]  beat_cnt
);
    logic              cap_load;
    logic              cap_adv;
    logic [ADDR_W-1:0] cap_addr;
    logic [ADDR_W-1:0] base_q;
    logic              run_q;

    burst_in_reg #(.ADDR_W(ADDR_W)) u_in (
        .clk(clk), .rst_n(rst_n),
        .strobe_cpu(strobe_cpu), .strobe_ctl(strobe_ctl),
        .advance(advance), .addr_in(addr_in),
        .cap_load(cap_load), .cap_adv(cap_adv), .cap_addr(cap_addr)
    );

    burst_seq_fsm #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cap_load(cap_load), .cap_adv(cap_adv), .cap_addr(cap_addr),
        .base_q(base_q), .cnt_q(beat_cnt), .run_q(run_q)
    );

    burst_addr_mix #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_mix (
        .mode_ilv(mode_ilv), .base_q(base_q), .cnt_q(beat_cnt),
        .addr_out(addr_out)
    );
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strobe_cpu,
    input logic              strobe_ctl,
    input logic              advance,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out,
    input logic [CNT_W-1:0]  beat_cnt,
    input logic              run_q
);
    logic start;
    assign start = strobe_cpu | strobe_ctl;

    // R2 / R8: a sampled start gives beat 0 two edges later
    a_r2_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start, 2) |-> (beat_cnt == '0));

    // R2: upper address bits follow the loaded address
    a_r2_load_addr: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start, 2) |-> (addr_out[ADDR_W-1:CNT_W] == $past(addr_in[ADDR_W-1:CNT_W], 2)));

    // R4: no start and no advance means beat holds
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(start, 2) && !$past(advance, 2)) |-> $stable(beat_cnt));

    // R4: an advance while running steps by one
    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(start, 2) && $past(advance, 2) && $past(run_q))
            |-> (beat_cnt == CNT_W'($past(beat_cnt) + 1'b1)));

    // R7: upper bits never move without a load
    a_r7_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(start, 2) |-> $stable(addr_out[ADDR_W-1:CNT_W]));

    // R9: idle ignores advance
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> (beat_cnt == '0 && addr_out == '0));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .strobe_cpu(strobe_cpu), .strobe_ctl(strobe_ctl),
    .advance(advance), .addr_in(addr_in), .addr_out(addr_out),
    .beat_cnt(beat_cnt), .run_q(run_q)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
    localparam int ADDR_W = 8;
    localparam int CNT_W  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mode_ilv = 1'b0;
    logic              strobe_cpu = 1'b0;
    logic              strobe_ctl = 1'b0;
    logic              advance = 1'b0;
    logic [ADDR_W-1:0] addr_in = '0;
    logic [ADDR_W-1:0] addr_out;
    logic [CNT_W-1:0]  beat_cnt;

    int checks = 0;
    int errors = 0;
    logic [ADDR_W-1:0] e_base;
    int                e_cnt;

    always #5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_ilv(mode_ilv),
        .strobe_cpu(strobe_cpu), .strobe_ctl(strobe_ctl),
        .advance(advance), .addr_in(addr_in),
        .addr_out(addr_out), .beat_cnt(beat_cnt)
    );

    function automatic logic [ADDR_W-1:0] model(input logic [ADDR_W-1:0] b,
                                                input int c, input logic ilv);
        logic [1:0] lo;
        if (ilv) lo = 2'(b[1:0] ^ 2'(c));
        else     lo = 2'((int'(b[1:0]) + c) % 4);
        return {b[ADDR_W-1:2], lo};
    endfunction

    task automatic chk(input string tag, input logic [ADDR_W-1:0] ea, input int ec);
        checks++;
        if (addr_out !== ea || beat_cnt !== CNT_W'(ec)) begin
            errors++;
            $display("FAIL %s: addr %h beat %0d, expected addr %h beat %0d",
                     tag, addr_out, beat_cnt, ea, ec);
        end
    endtask

    // Present a start for one cycle, result visible two negedges later.
    task automatic do_load(input logic [ADDR_W-1:0] a, input int sel, input logic adv);
        strobe_cpu = (sel != 1);
        strobe_ctl = (sel != 0);
        advance    = adv;
        addr_in    = a;
        @(negedge clk);
        strobe_cpu = 1'b0; strobe_ctl = 1'b0; advance = 1'b0;
        @(negedge clk);
        e_base = a; e_cnt = 0;
    endtask

    task automatic do_adv();
        advance = 1'b1;
        @(negedge clk);
        advance = 1'b0;
        @(negedge clk);
        e_cnt = (e_cnt + 1) % 4;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset", '0, 0);

        do_adv();
        chk("R9 idle advance", '0, 0);
        do_adv();
        chk("R9 idle advance again", '0, 0);

        for (int m = 0; m < 2; m++) begin
            mode_ilv = m[0];
            for (int lo = 0; lo < 4; lo++) begin
                for (int sel = 0; sel < 3; sel++) begin
                    logic [ADDR_W-1:0] a;
                    a = {6'(17 * (lo + 1) + sel * 5 + m * 3), 2'(lo)};
                    do_load(a, sel, 1'b0);
                    chk(sel == 2 ? "R3 dual strobe load" : "R2 load", model(e_base, 0, mode_ilv), 0);
                    for (int s = 0; s < 6; s++) begin
                        do_adv();
                        chk(m ? "R6 interleaved step" : "R5 linear step",
                            model(e_base, e_cnt, mode_ilv), e_cnt);
                        if (e_cnt == 0) chk("R7 wrap to start", e_base, 0);
                    end
                    @(negedge clk);
                    chk("R4 hold without advance", model(e_base, e_cnt, mode_ilv), e_cnt);
                end
            end
        end

        mode_ilv = 1'b0;
        do_load(8'hC7, 0, 1'b0);
        do_adv();
        do_adv();
        chk("R4 two steps", model(8'hC7, 2, 1'b0), 2);
        do_load(8'h3A, 1, 1'b1);
        chk("R8 reload mid-burst", 8'h3A, 0);
        do_adv();
        chk("R8 step after reload", model(8'h3A, 1, 1'b0), 1);

        do_load(8'h93, 0, 1'b0);
        do_adv();
        chk("R10 linear before flip", model(8'h93, 1, 1'b0), 1);
        mode_ilv = 1'b1;
        #1;
        chk("R10 flip to interleaved", model(8'h93, 1, 1'b1), 1);
        mode_ilv = 1'b0;
        #1;
        chk("R10 flip back to linear", model(8'h93, 1, 1'b0), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: timeout, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule